// File: doc/BRIEF.md
# Addressed Packet Receiver with Check Byte

This block sits behind a line decoder and works on whole bytes. A start strobe opens a packet and an end strobe closes it. Between them the first byte is taken as the target address, the last byte as a check byte, and every byte in between as payload. The check byte is the XOR of the address byte and all payload bytes. While bytes arrive, the receiver folds every byte, including the check byte, into a running XOR. A correct packet therefore leaves a zero result.

Payload bytes go into a local buffer and are held there until the packet has passed both tests: a zero check result and an address equal to `own_id`. A passing packet raises a one-cycle `pkt_good` and then streams its payload, one byte per cycle. When the last byte has gone out, `reply_req` pulses to tell the local controller it may now answer the sender, as a half-duplex slave would. A packet with a check failure, one that is too short, or one that overruns the buffer produces a one-cycle `pkt_err` and delivers nothing. A packet that is intact but addressed elsewhere is dropped without any visible effect.

Top module: `mpk_rx`

## Requirements
- R1: After reset, `out_valid`, `out_last`, `pkt_good`, `pkt_err` and `reply_req` are all low.
- R2: `rx_start` begins collection. `rx_valid` bytes and `rx_end` that arrive outside an open packet are ignored. An `rx_start` inside an open packet discards what was collected so far and begins again.
- R3: Within a packet, byte 0 is the address, the final byte before `rx_end` is the check byte, and the bytes in between are the payload, in arrival order.
- R4: If the XOR of the address, the payload and the check byte is not zero, `pkt_err` is high for exactly one cycle, starting the cycle after `rx_end` is sampled. In that case no payload is output and `pkt_good` stays low.
- R5: A packet whose check byte is correct but whose address differs from `own_id` causes no `pkt_good`, no `pkt_err`, no payload and no `reply_req`.
- R6: A correct packet addressed to `own_id` raises `pkt_good` for one cycle, starting the cycle after `rx_end`. Its payload appears on `out_byte` with `out_valid` from that same cycle, one byte per cycle, and `out_last` marks the final byte.
- R7: `reply_req` pulses for one cycle once per accepted packet. It comes the cycle after the last payload byte, or together with `pkt_good` when the payload is empty.
- R8: A packet with more than `MAX_LEN` payload bytes is aborted. The first byte that cannot be stored (byte index `MAX_LEN`+2) causes a one-cycle `pkt_err` in the next cycle. All later bytes and the end strobe are then ignored until the next `rx_start`.
- R9: An `rx_end` that arrives after fewer than two bytes (no address and check byte pair) gives a one-cycle `pkt_err` and no payload.
- R10: While an accepted payload is being streamed out, `rx_start`, `rx_valid` and `rx_end` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_id | input | W | Local device address |
| rx_start | input | 1 | Start-of-packet strobe |
| rx_end | input | 1 | End-of-packet strobe |
| rx_valid | input | 1 | `rx_byte` holds a data byte |
| rx_byte | input | W | Decoded byte |
| out_valid | output | 1 | Payload byte valid |
| out_byte | output | W | Payload byte |
| out_last | output | 1 | Final payload byte |
| pkt_good | output | 1 | Packet accepted pulse |
| pkt_err | output | 1 | Packet rejected pulse |
| reply_req | output | 1 | Request to send a reply |

## Verification
The bench builds the receiver with `MAX_LEN` = 4 and `W` = 8. With a buffer this small, the overflow abort can be reached with packets only a few bytes long, and the boundary between a full buffer and an overrun (4 versus 5 payload bytes) is tested directly. The packets that are sent cover an empty payload, a full payload, a corrupted check byte, a foreign address, runt packets, a restarted packet, and strobes that arrive during payload delivery.

// File: rtl/mpk_rx.sv
module mpk_rx #(
  parameter int MAX_LEN = 8,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] own_id,
  input  logic         rx_start,
  input  logic         rx_end,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         out_valid,
  output logic [W-1:0] out_byte,
  output logic         out_last,
  output logic         pkt_good,
  output logic         pkt_err,
  output logic         reply_req
);
  localparam int CW = $clog2(MAX_LEN + 3);
  localparam int SLOTS = 1 << CW;
  localparam logic [CW-1:0] FULL = CW'(MAX_LEN + 2);
  localparam logic [CW-1:0] MINB = CW'(2);

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_DRAIN, S_DROP} st_t;

  st_t           state;
  logic [CW-1:0] cnt, rd, plen;
  logic [W-1:0]  acc, id_q;
  logic [W-1:0]  mem [SLOTS];
  logic          good_q, err_q, rep_q;

  wire take = (state == S_COLL) && !rx_start && !rx_end && rx_valid && (cnt != FULL);

  always_ff @(posedge clk) begin
    if (take && cnt != '0) mem[cnt - 1'b1] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rd     <= '0;
      plen   <= '0;
      acc    <= '0;
      id_q   <= '0;
      good_q <= 1'b0;
      err_q  <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      good_q <= 1'b0;
      err_q  <= 1'b0;
      rep_q  <= 1'b0;
      case (state)
        S_IDLE, S_DROP: begin
          if (rx_start) begin
            state <= S_COLL;
            cnt   <= '0;
            acc   <= '0;
          end
        end
        S_COLL: begin
          if (rx_start) begin
            cnt <= '0;
            acc <= '0;
          end else if (rx_end) begin
            state <= S_IDLE;
            if (cnt < MINB || acc != '0) begin
              err_q <= 1'b1;
            end else if (id_q == own_id) begin
              good_q <= 1'b1;
              plen   <= cnt - MINB;
              rd     <= '0;
              if (cnt == MINB) rep_q <= 1'b1;
              else state <= S_DRAIN;
            end
          end else if (rx_valid) begin
            if (cnt == FULL) begin
              err_q <= 1'b1;
              state <= S_DROP;
            end else begin
              acc <= acc ^ rx_byte;
              if (cnt == '0) id_q <= rx_byte;
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DRAIN: begin
          rd <= rd + 1'b1;
          if (rd == plen - 1'b1) begin
            state <= S_IDLE;
            rep_q <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign out_valid = (state == S_DRAIN);
  assign out_byte  = mem[rd];
  assign out_last  = out_valid && (rd == plen - 1'b1);
  assign pkt_good  = good_q;
  assign pkt_err   = err_q;
  assign reply_req = rep_q;
endmodule

// File: rtl/mpk_rx_chk.sv
module mpk_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_last,
  input logic pkt_good,
  input logic pkt_err,
  input logic reply_req
);
  a_r4_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |=> !pkt_err);
  a_r4_no_good_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_good && pkt_err));
  a_r4_no_payload_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |-> !out_valid);
  a_r6_stream_opens_with_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> pkt_good);
  a_r6_last_inside_stream: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r7_reply_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> reply_req && !out_valid);
  a_r7_reply_single: assert property (@(posedge clk) disable iff (!rst_n)
    reply_req |=> !reply_req);
endmodule

bind mpk_rx mpk_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_last(out_last),
  .pkt_good(pkt_good), .pkt_err(pkt_err), .reply_req(reply_req)
);

// File: tb/mpk_rx_tb.sv
module mpk_rx_tb;
  localparam int TCLK = 10;
  localparam int MAXL = 4;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start = 1'b0, rx_end = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic out_valid, out_last, pkt_good, pkt_err, reply_req;
  logic [7:0] out_byte;

  int checks = 0, fails = 0, cyc = 0;
  int   q_kind[$];
  logic [7:0] q_b[$];
  logic q_last[$];
  string q_req[$];
  logic [7:0] pl [8];

  always #(TCLK/2) clk = ~clk;

  mpk_rx #(.MAX_LEN(MAXL), .W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .own_id(OWN), .rx_start(rx_start), .rx_end(rx_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .out_valid(out_valid), .out_byte(out_byte),
    .out_last(out_last), .pkt_good(pkt_good), .pkt_err(pkt_err), .reply_req(reply_req));

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      summary_and_end();
    end
  end

  task automatic expect_item(int k, logic [7:0] b, logic l, string r);
    q_kind.push_back(k); q_b.push_back(b); q_last.push_back(l); q_req.push_back(r);
  endtask

  task automatic observe(int k, logic [7:0] b, logic l);
    checks++;
    if (q_kind.size() == 0) begin
      fails++;
      $display("FAIL unexpected: actual kind %0d byte %h, expected nothing", k, b);
    end else begin
      int ek = q_kind.pop_front();
      logic [7:0] eb = q_b.pop_front();
      logic el = q_last.pop_front();
      string er = q_req.pop_front();
      if (ek != k || (k == 2 && (eb != b || el != l))) begin
        fails++;
        $display("FAIL %s: actual kind %0d byte %h last %0b, expected kind %0d byte %h last %0b",
                 er, k, b, l, ek, eb, el);
      end
    end
  endtask

  // monitor: kinds 0 good, 1 err, 2 payload byte, 3 reply
  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_good) observe(0, 8'h00, 1'b0);
      if (pkt_err) observe(1, 8'h00, 1'b0);
      if (out_valid) observe(2, out_byte, out_last);
      if (reply_req) observe(3, 8'h00, 1'b0);
    end
  end

  task automatic drive(bit s, bit e, bit v, logic [7:0] b);
    @(negedge clk);
    rx_start = s; rx_end = e; rx_valid = v; rx_byte = b;
    @(negedge clk);
    rx_start = 0; rx_end = 0; rx_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // sends start, id, n payload bytes from pl, check byte, end
  task automatic send_pkt(logic [7:0] id, int n, bit corrupt);
    logic [7:0] bcc = id;
    for (int i = 0; i < n; i++) bcc ^= pl[i];
    if (corrupt) bcc ^= 8'h01;
    if (n > MAXL) expect_item(1, 0, 0, "R8");
    else if (corrupt) expect_item(1, 0, 0, "R4");
    else if (id == OWN) begin
      expect_item(0, 0, 0, "R6");
      for (int i = 0; i < n; i++) expect_item(2, pl[i], i == n - 1, "R3");
      expect_item(3, 0, 0, "R7");
    end
    drive(1, 0, 0, 0);
    drive(0, 0, 1, id);
    for (int i = 0; i < n; i++) drive(0, 0, 1, pl[i]);
    drive(0, 0, 1, bcc);
    drive(0, 1, 0, 0);
  endtask

  initial begin
    idle(2);
    checks++;
    if (out_valid || out_last || pkt_good || pkt_err || reply_req) begin
      fails++;
      $display("FAIL R1: actual %0b%0b%0b%0b%0b, expected 00000",
               out_valid, out_last, pkt_good, pkt_err, reply_req);
    end
    rst_n = 1'b1;
    idle(2);

    pl[0] = 8'h11; pl[1] = 8'hA3; pl[2] = 8'h00; pl[3] = 8'hFF; pl[4] = 8'h42;
    send_pkt(OWN, 3, 0); idle(8);        // R6 basic
    send_pkt(OWN, 0, 0); idle(8);        // R7 empty payload
    send_pkt(OWN, MAXL, 0); idle(10);    // R3 full buffer
    send_pkt(OWN, 2, 1); idle(8);        // R4 corrupted check
    send_pkt(8'h33, 2, 0); idle(8);      // R5 foreign address
    send_pkt(OWN, MAXL + 1, 0); idle(8); // R8 overrun
    drive(0, 0, 1, 8'h77); drive(0, 1, 0, 0); idle(4);  // R2 stray bytes
    expect_item(1, 0, 0, "R9");
    drive(1, 0, 0, 0); drive(0, 0, 1, OWN); drive(0, 1, 0, 0); idle(4);
    expect_item(1, 0, 0, "R9");
    drive(1, 0, 0, 0); drive(0, 1, 0, 0); idle(4);
    drive(1, 0, 0, 0); drive(0, 0, 1, 8'h99); drive(0, 0, 1, 8'h98); // R2 restart
    pl[0] = 8'hC4; pl[1] = 8'h3C;
    send_pkt(OWN, 2, 0); idle(8);
    // R10: strobes during delivery are ignored
    pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03; pl[3] = 8'h04;
    send_pkt(OWN, 4, 0);
    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0; rx_valid = 1; rx_byte = 8'hEE;
    @(negedge clk); rx_valid = 0; rx_end = 1;
    @(negedge clk); rx_end = 0;
    idle(10);

    checks++;
    if (q_kind.size() != 0) begin
      fails++;
      $display("FAIL R6: actual %0d items outstanding, expected 0", q_kind.size());
    end
    summary_and_end();
  end
endmodule